// File: doc/BRIEF.md
# I2C Target Controller with Software-Steered Status

This block is a byte-oriented I2C target (slave) that sits on a simple microcontroller register bus. It watches the two bus lines for START and STOP, shifts in the first byte after each START, and compares its upper seven bits with a programmed own address. On a hit it acknowledges, records the transfer direction, and raises an interrupt. Software then moves every following byte through one shared data register.

Software runs the whole transfer from a small set of sticky status bits: bus busy, address hit, transmit direction and "last byte not acknowledged". The interrupt request fires on an address hit and after every completed byte. Software tells the two cases apart by reading the address-hit bit. After each byte the controller holds SCL low until software services the data register. In receive mode that service is a read. In transmit mode it is a write. Reception therefore starts with a dummy read of the data register.

The register bus uses three selector codes: 0 is the own-address register, 1 is status and control, and 2 is data. Writes take effect on the clock edge where `reg_wr` is high. Reads are combinational from `reg_sel`. The bus lines are open-drain: the block pulls a line low by raising the matching `*_low_o` output.

Top module: `i2c_tgt_ctrl`

## Requirements
- R1: The status bit 0 (busy) becomes 1 after a START (SDA falling while SCL is high) and returns to 0 after a STOP (SDA rising while SCL is high).
- R2: Bits 7..1 of the own-address register (selector 0) hold the 7-bit own address. Bit 0 is not stored, reads as 0, and has no effect on matching.
- R3: After a START the first byte is taken MSB first, with bits 7..1 as the address and bit 0 as read/write. On a match the status bit 1 (address hit) is set and SDA is pulled low on the ninth clock. On a mismatch the bit is cleared, no acknowledge is given, no interrupt is raised, and the bus is ignored until the next START.
- R4: The status bit 2 (transmit) takes the read/write bit of a matching address byte. A value of 1 means the master reads and the target transmits.
- R5: The status bit 7 (interrupt pending) and the `irq_o` output are set on an address match and after every completed data byte. Writing status with bit 7 = 1 clears them.
- R6: In receive mode each data byte is sampled on SCL rising edges MSB first, acknowledged on the ninth clock, and placed in the data register (selector 2).
- R7: After the ninth clock of an acknowledged byte, SCL is held low until software reads the data register (receive) or writes it (transmit). The dummy read after an address match releases the bus for reception.
- R8: In transmit mode the data register is sent MSB first. The master's ninth-bit response is stored in the status bit 3 (0 = acknowledged, 1 = not). On a not-acknowledge, SDA and SCL stay released and the target waits for the next START or STOP.
- R9: The target changes its SDA drive only while the synchronized SCL is low, or at a START or STOP.
- R10: After reset the status reads 0, `irq_o` is 0 and both bus lines are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 2 | Register selector (0 own address, 1 status, 2 data) |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data register reads count as service) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_sel` |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_low_o | output | 1 | Pull SCL low (clock hold) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge or data 0) |
| irq_o | output | 1 | Interrupt request, level |

## Verification
The hardest situation to reach is the hand-off between the clock hold and the software service. The bench stops the master model at the end of each ninth clock and confirms that SCL is still held low. It then performs the data register read or write. The master cannot raise SCL until the controller lets go, so the first transmit bit has to appear on SDA at the moment the hold is released. The not-acknowledge exit from transmit mode is reached by having the master answer the second byte with a 1 and then checking that both lines are free without any software action.

// File: rtl/i2c_tgt_pkg.sv
// Package: shared constants and the link state type for the I2C target.
// Assumes a 7-bit address and 8-bit bytes, as the bus protocol fixes them.
package i2c_tgt_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 7;
    localparam int SEL_W    = 2;
    localparam int BITCNT_W = 4;

    localparam logic [SEL_W-1:0] SEL_OWN  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd1;
    localparam logic [SEL_W-1:0] SEL_DATA = 2'd2;

    localparam int STAT_IRQ_BIT = 7;

    typedef enum logic [2:0] {
        LS_IDLE,
        LS_ADDR,
        LS_RX,
        LS_ACK_OUT,
        LS_HOLD,
        LS_TX,
        LS_TX_ACK
    } link_st_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
// Module: synchronizes SCL and SDA and derives START, STOP and SCL edges.
// Assumes both lines idle high. Every detector output is a one-cycle pulse.
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    localparam int LINES = 2;

    logic [LINES-1:0] raw_in;
    logic [LINES-1:0] synced;
    logic [LINES-1:0] prev;

    assign raw_in = {sda_raw, scl_raw};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;

        // Shift one line through its synchronizer chain (reset to idle high).
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[STAGES-2:0], raw_in[g]};
        end

        assign synced[g] = pipe[STAGES-1];
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '1;
        else        prev <= synced;
    end

    assign scl_s     = synced[0];
    assign sda_s     = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/i2c_tgt_link.sv
// Module: bit-level target state machine (address, receive, transmit, hold).
// Assumes synchronized inputs and single-cycle edge pulses from i2c_tgt_sync.
// SCL is held low after each acknowledged byte until svc_done is seen.
module i2c_tgt_link
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              svc_done,
    output logic              busy,
    output logic              hit,
    output logic              dir_tx,
    output logic              nack,
    output logic              byte_evt,
    output logic              rx_load,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              scl_low,
    output logic              sda_low
);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);
    localparam logic [BITCNT_W-1:0] BYTE_END = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] ACK_END  = BITCNT_W'(BYTE_W + 1);

    link_st_t            state;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BYTE_W-1:0]   shreg;

    assign rx_byte = shreg;

    // Advance the link state machine and its flags on synchronized bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LS_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            busy     <= 1'b0;
            hit      <= 1'b0;
            dir_tx   <= 1'b0;
            nack     <= 1'b0;
            byte_evt <= 1'b0;
            rx_load  <= 1'b0;
            scl_low  <= 1'b0;
            sda_low  <= 1'b0;
        end else begin
            byte_evt <= 1'b0;
            rx_load  <= 1'b0;
            if (start_det) begin
                busy    <= 1'b1;
                state   <= LS_ADDR;
                bit_cnt <= '0;
                scl_low <= 1'b0;
                sda_low <= 1'b0;
            end else if (stop_det) begin
                busy    <= 1'b0;
                state   <= LS_IDLE;
                scl_low <= 1'b0;
                sda_low <= 1'b0;
            end else begin
                unique case (state)
                    LS_ADDR: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_bit};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                if (shreg[ADDR_W-1:0] == own_addr) begin
                                    hit      <= 1'b1;
                                    dir_tx   <= sda_bit;
                                    byte_evt <= 1'b1;
                                end else begin
                                    hit <= 1'b0;
                                end
                            end
                        end else if (scl_fall && bit_cnt == BYTE_END) begin
                            if (hit) begin
                                sda_low <= 1'b1;
                                state   <= LS_ACK_OUT;
                            end else begin
                                state <= LS_IDLE;
                            end
                        end
                    end
                    LS_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_bit};
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt == LAST_BIT) begin
                                rx_load  <= 1'b1;
                                byte_evt <= 1'b1;
                            end
                        end else if (scl_fall && bit_cnt == BYTE_END) begin
                            sda_low <= 1'b1;
                            state   <= LS_ACK_OUT;
                        end
                    end
                    LS_ACK_OUT: begin
                        if (scl_fall) begin
                            sda_low <= 1'b0;
                            scl_low <= 1'b1;
                            state   <= LS_HOLD;
                        end
                    end
                    LS_HOLD: begin
                        if (svc_done) begin
                            scl_low <= 1'b0;
                            bit_cnt <= '0;
                            if (dir_tx) begin
                                shreg   <= tx_byte;
                                sda_low <= ~tx_byte[BYTE_W-1];
                                state   <= LS_TX;
                            end else begin
                                state <= LS_RX;
                            end
                        end
                    end
                    LS_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt != '0) begin
                            if (bit_cnt == BYTE_END) begin
                                sda_low <= 1'b0;
                                state   <= LS_TX_ACK;
                            end else begin
                                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                                sda_low <= ~shreg[BYTE_W-2];
                            end
                        end
                    end
                    LS_TX_ACK: begin
                        if (scl_rise) begin
                            nack     <= sda_bit;
                            byte_evt <= 1'b1;
                            bit_cnt  <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == ACK_END) begin
                            if (nack) begin
                                state <= LS_IDLE;
                            end else begin
                                scl_low <= 1'b1;
                                state   <= LS_HOLD;
                            end
                        end
                    end
                    default: begin
                        state <= LS_IDLE;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_tgt_regs.sv
// Module: software-visible registers (own address, status/control, data).
// Assumes single-cycle strobes. A data read or write is the hold service.
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              hit,
    input  logic              dir_tx,
    input  logic              nack,
    input  logic              byte_evt,
    input  logic              rx_load,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [ADDR_W-1:0] own_addr,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              svc_done,
    output logic              irq
);
    logic wr_own, wr_stat, wr_data, rd_data;

    assign wr_own  = reg_wr && reg_sel == SEL_OWN;
    assign wr_stat = reg_wr && reg_sel == SEL_STAT;
    assign wr_data = reg_wr && reg_sel == SEL_DATA;
    assign rd_data = reg_rd && reg_sel == SEL_DATA;

    // Store the own address from write-data bits 7..1.
    always_ff @(posedge clk) begin
        if (!rst_n)      own_addr <= '0;
        else if (wr_own) own_addr <= reg_wdata[BYTE_W-1:1];
    end

    // Shared data register: a received byte wins over a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_byte <= '0;
        else if (rx_load) tx_byte <= rx_byte;
        else if (wr_data) tx_byte <= reg_wdata;
    end

    // Interrupt pending: set per event, cleared by writing 1 to its status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  irq <= 1'b0;
        else if (byte_evt)                           irq <= 1'b1;
        else if (wr_stat && reg_wdata[STAT_IRQ_BIT]) irq <= 1'b0;
    end

    // Service latch: cleared per byte event, set by the access that the direction needs.
    always_ff @(posedge clk) begin
        if (!rst_n)                              svc_done <= 1'b0;
        else if (byte_evt)                       svc_done <= 1'b0;
        else if (dir_tx ? wr_data : rd_data)     svc_done <= 1'b1;
    end

    // Combinational read-back multiplexer.
    always_comb begin
        unique case (reg_sel)
            SEL_OWN:  reg_rdata = {own_addr, 1'b0};
            SEL_STAT: reg_rdata = {irq, 3'b000, nack, dir_tx, hit, busy};
            SEL_DATA: reg_rdata = tx_byte;
            default:  reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/i2c_tgt_ctrl.sv
// Module: top of the I2C target controller. It wires the synchronizer, the link
// state machine and the register file. It assumes open-drain pads outside:
// a high *_low_o output pulls the line low.
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  reg_sel,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_low_o,
    output logic              sda_low_o,
    output logic              irq_o
);
    logic              scl_s, sda_s;
    logic              start_det, stop_det, scl_rise, scl_fall;
    logic              busy, hit, dir_tx, nack;
    logic              byte_evt, rx_load, svc_done;
    logic [BYTE_W-1:0] rx_byte, tx_byte;
    logic [ADDR_W-1:0] own_addr;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    i2c_tgt_link u_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_bit   (sda_s),
        .own_addr  (own_addr),
        .tx_byte   (tx_byte),
        .svc_done  (svc_done),
        .busy      (busy),
        .hit       (hit),
        .dir_tx    (dir_tx),
        .nack      (nack),
        .byte_evt  (byte_evt),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .scl_low   (scl_low_o),
        .sda_low   (sda_low_o)
    );

    i2c_tgt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .hit       (hit),
        .dir_tx    (dir_tx),
        .nack      (nack),
        .byte_evt  (byte_evt),
        .rx_load   (rx_load),
        .rx_byte   (rx_byte),
        .own_addr  (own_addr),
        .tx_byte   (tx_byte),
        .svc_done  (svc_done),
        .irq       (irq_o)
    );

endmodule

// File: rtl/i2c_tgt_chk.sv
// Checker: temporal properties of the I2C target, bound into i2c_tgt_ctrl.
// Assumes it is attached to the internal detector and flag nets by name.
module i2c_tgt_chk (
    input logic clk,
    input logic rst_n,
    input logic start_det,
    input logic stop_det,
    input logic scl_fall,
    input logic scl_s,
    input logic busy,
    input logic byte_evt,
    input logic irq_o,
    input logic irq_clr_wr,
    input logic scl_low_o,
    input logic sda_low_o
);
    // R1: a START marks the bus busy on the next cycle.
    a_r1_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> busy);

    // R1: a STOP frees the bus on the next cycle.
    a_r1_free_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> !busy);

    // R5: every byte event leaves an interrupt pending.
    a_r5_irq_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        byte_evt |=> irq_o);

    // R5: a write-one-to-clear without a competing event drops the request.
    a_r5_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_wr && !byte_evt) |=> !irq_o);

    // R7: the clock hold starts right after an SCL falling edge.
    a_r7_hold_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low_o) |-> $past(scl_fall));

    // R9: SDA drive changes only while SCL is low, or on START/STOP.
    a_r9_sda_when_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_low_o) |-> (!$past(scl_s) || $past(start_det) || $past(stop_det)));

endmodule

bind i2c_tgt_ctrl i2c_tgt_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .scl_fall   (scl_fall),
    .scl_s      (scl_s),
    .busy       (busy),
    .byte_evt   (byte_evt),
    .irq_o      (irq_o),
    .irq_clr_wr (reg_wr && (reg_sel == 2'd1) && reg_wdata[7]),
    .scl_low_o  (scl_low_o),
    .sda_low_o  (sda_low_o)
);

// File: tb/i2c_tgt_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_tgt_ctrl_tb;

    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       scl_low_o, sda_low_o, irq_o;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       scl_line, sda_line;

    int n_chk = 0;
    int n_fail = 0;

    assign scl_line = scl_m & ~scl_low_o;
    assign sda_line = sda_m & ~sda_low_o;

    always #2 clk = ~clk;

    i2c_tgt_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .scl_i     (scl_line),
        .sda_i     (sda_line),
        .scl_low_o (scl_low_o),
        .sda_low_o (sda_low_o),
        .irq_o     (irq_o)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    task automatic m_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_scl_high(); wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic m_bit_w(input logic b);
        sda_m = b; wait_q();
        scl_m = 1'b1; wait_scl_high(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic m_bit_r(output logic b);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_scl_high(); wait_q();
        b = sda_line;
        scl_m = 1'b0; wait_q();
    endtask

    task automatic m_byte_w(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) m_bit_w(d[i]);
        m_bit_r(ack);
    endtask

    task automatic m_byte_r(input logic nack_bit, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) m_bit_r(d[i]);
        m_bit_w(nack_bit);
    endtask

    // R10: reset state of the status register and the outputs.
    task automatic t_reset();
        logic [7:0] d;
        reg_read(2'd1, d);
        chk("R10 status after reset", d, 8'h00);
        chk("R10 irq after reset", {7'd0, irq_o}, 8'h00);
        chk("R10 lines released", {6'd0, scl_low_o, sda_low_o}, 8'h00);
    endtask

    // R2: own-address bit 0 is not stored.
    task automatic t_own_addr();
        logic [7:0] d;
        reg_write(2'd0, 8'hA5);
        reg_read(2'd0, d);
        chk("R2 own address readback", d, 8'hA4);
    endtask

    // R1 R3 R4 R5 R6 R7: master writes two bytes.
    task automatic t_write_xfer();
        logic [7:0] d;
        logic ack;
        m_start();
        reg_read(2'd1, d);
        chk("R1 busy after START", {7'd0, d[0]}, 8'h01);
        m_byte_w(8'hA4, ack);
        chk("R3 address ACK (bit0 of own ignored, R2)", {7'd0, ack}, 8'h00);
        chk("R7 SCL held after address", {7'd0, scl_low_o}, 8'h01);
        reg_read(2'd1, d);
        chk("R4 R5 status after write-address match", d, 8'h83);
        chk("R5 irq pin on match", {7'd0, irq_o}, 8'h01);
        reg_write(2'd1, 8'h80);
        chk("R5 irq cleared by write-one", {7'd0, irq_o}, 8'h00);
        reg_read(2'd2, d);
        repeat (4) @(negedge clk);
        chk("R7 dummy read releases SCL", {7'd0, scl_low_o}, 8'h00);
        m_byte_w(8'h3C, ack);
        chk("R6 data ACK byte 1", {7'd0, ack}, 8'h00);
        chk("R5 irq after byte 1", {7'd0, irq_o}, 8'h01);
        chk("R7 SCL held after byte 1", {7'd0, scl_low_o}, 8'h01);
        reg_read(2'd2, d);
        chk("R6 received byte 1", d, 8'h3C);
        reg_write(2'd1, 8'h80);
        m_byte_w(8'hC3, ack);
        chk("R6 data ACK byte 2", {7'd0, ack}, 8'h00);
        reg_read(2'd2, d);
        chk("R6 received byte 2", d, 8'hC3);
        reg_write(2'd1, 8'h80);
        m_stop();
        reg_read(2'd1, d);
        chk("R1 busy cleared by STOP", d, 8'h02);
    endtask

    // R4 R5 R7 R8: master reads two bytes and NACKs the last one.
    task automatic t_read_xfer();
        logic [7:0] d;
        logic ack;
        m_start();
        m_byte_w(8'hA5, ack);
        chk("R3 read-address ACK", {7'd0, ack}, 8'h00);
        reg_read(2'd1, d);
        chk("R4 status after read-address match", d, 8'h87);
        chk("R7 SCL held before first transmit", {7'd0, scl_low_o}, 8'h01);
        reg_write(2'd1, 8'h80);
        reg_write(2'd2, 8'h96);
        m_byte_r(1'b0, d);
        chk("R8 transmitted byte 1", d, 8'h96);
        reg_read(2'd1, d);
        chk("R8 ACK recorded", d, 8'h87);
        chk("R7 SCL held after acked transmit", {7'd0, scl_low_o}, 8'h01);
        reg_write(2'd1, 8'h80);
        reg_write(2'd2, 8'h5A);
        m_byte_r(1'b1, d);
        chk("R8 transmitted byte 2", d, 8'h5A);
        reg_read(2'd1, d);
        chk("R8 NACK recorded", {7'd0, d[3]}, 8'h01);
        chk("R8 lines released after NACK", {6'd0, scl_low_o, sda_low_o}, 8'h00);
        reg_write(2'd1, 8'h80);
        m_stop();
    endtask

    // R3: address mismatch is ignored until the next START.
    task automatic t_mismatch();
        logic [7:0] d;
        logic ack;
        m_start();
        m_byte_w(8'h40, ack);
        chk("R3 no ACK on mismatch", {7'd0, ack}, 8'h01);
        reg_read(2'd1, d);
        chk("R3 hit cleared on mismatch", {7'd0, d[1]}, 8'h00);
        chk("R3 no irq on mismatch", {7'd0, irq_o}, 8'h00);
        m_byte_w(8'h00, ack);
        chk("R3 following byte ignored", {7'd0, ack}, 8'h01);
        chk("R3 no hold after mismatch", {7'd0, scl_low_o}, 8'h00);
        m_stop();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_own_addr();
        t_write_xfer();
        t_read_xfer();
        t_mismatch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule